// File: doc/BRIEF.md
# Dual-Alarm Power-Enable Controller

This block sits beside a real-time calendar counter. It watches the current BCD calendar time that the counter supplies. It holds two six-field BCD alarm sets: a primary wake alarm and a second alarm that shuts power down. Each alarm matches at most once for each time update. Matches are recorded in sticky status bits, and enabled status bits drive an interrupt line.

When software sets the power-control enable, a match of the shutdown alarm drives the external power-enable pin to its OFF level, and a later match of the wake alarm drives it back ON. A typical power-off sequence does four things: set the enable, load the shutdown alarm a couple of seconds ahead of the current time, enable its interrupt, and wait for the regulator to cut supply. The wake alarm then restores power. While the enable is clear, the alarms only report status.

All registers sit on a simple word-wide bus. Writes take one cycle and reads are combinational.

Top module: `dual_alarm_pwr_ctl`

## Requirements
- R1: After reset, pwr_en is high, irq is low, and every mapped register reads as zero apart from the live busy bit.
- R2: The shutdown alarm fields are seconds, minutes, hours, day, month and year, at byte offsets 0x80, 0x84, 0x88, 0x8C, 0x90 and 0x94. The wake alarm uses the same field order at 0x20 through 0x34. Each field stores the low 8 bits of a write, and its upper bits read as zero.
- R3: An alarm event occurs only in a cycle where cur_time differs from its value in the previous cycle and all six fields equal that alarm's fields. A partial match gives no event, and holding the time steady gives no further event.
- R4: In the status register at 0x44, bit 7 is the sticky shutdown-alarm flag, bit 6 is the sticky wake-alarm flag, and bit 0 reflects time_busy. Writing 1 to bit 7 or bit 6 clears that flag. If an event and a clear arrive in the same cycle, the flag stays set.
- R5: In the interrupt-enable register at 0x48, bit 4 enables the shutdown alarm, bit 3 enables the wake alarm, and bit 2 is the periodic-timer enable, which is stored and read back. A full 32-bit write updates all three bits. All other bits read as zero.
- R6: irq is high exactly while (status bit 7 and enable bit 4) or (status bit 6 and enable bit 3).
- R7: In the power-control register at 0x98, bit 16 is the only stored bit. It enables control of pwr_en.
- R8: With bit 16 set, a shutdown-alarm event drives pwr_en low at the clock edge where the event is seen. A later wake-alarm event drives it high again.
- R9: If both alarms match at the same edge while control is enabled, pwr_en goes low.
- R10: While bit 16 is clear, alarm events still set the status flags, and pwr_en keeps its level.
- R11: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_time | input | 48 | Current BCD time; seconds in [7:0], then minutes, hours, day, month, year in [47:40] |
| time_busy | input | 1 | High while the time counter is about to update |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwr_en | output | 1 | External regulator enable; high means ON |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume two things about the inputs. First, cur_time changes only as a whole value from one clock to the next, and each new value is a single time update. Second, software writes alarm fields only while time_busy is low, so the compare never sees a half-written alarm at an update. The stimulus changes cur_time and the bus only on falling clock edges, one step per cycle. Alarm registers are loaded only in cycles where the time is held, with one exception: a single directed case deliberately makes a status clear coincide with an update.

// File: rtl/dapc_pkg.sv
package dapc_pkg;
   localparam int FLD_W   = 8;
   localparam int NUM_FLD = 6;
   localparam int CAL_W   = FLD_W * NUM_FLD;
   localparam int NUM_ALM = 2;
   // alarm bank index
   localparam int ALM_WAKE = 0;
   localparam int ALM_SHUT = 1;
   // status bit positions
   localparam int STS_SHUT_BIT = 7;
   localparam int STS_WAKE_BIT = 6;
   localparam int STS_BUSY_BIT = 0;
   // interrupt-enable bit positions
   localparam int IEN_SHUT_BIT = 4;
   localparam int IEN_WAKE_BIT = 3;
   localparam int IEN_TMR_BIT  = 2;

   typedef logic [FLD_W-1:0] fld_t;
   typedef enum logic {PWR_ON = 1'b0, PWR_OFF = 1'b1} pwr_st_e;
endpackage

// File: rtl/dapc_tick.sv
module dapc_tick
   import dapc_pkg::*;
#(
   parameter int TIME_W = CAL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] cur_time,
   output logic              upd
);
   logic [TIME_W-1:0] time_q;
   logic              primed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         time_q   <= '0;
         primed_q <= 1'b0;
      end else begin
         time_q   <= cur_time;
         primed_q <= 1'b1;
      end
   end

   assign upd = primed_q && (cur_time != time_q);
endmodule

// File: rtl/dapc_match.sv
module dapc_match
   import dapc_pkg::*;
#(
   parameter int NF = NUM_FLD,
   parameter int FW = FLD_W
) (
   input  logic [NF*FW-1:0] cur_time,
   input  logic [NF*FW-1:0] alarm,
   input  logic             upd,
   output logic             hit
);
   logic [NF-1:0] fld_eq;

   for (genvar f = 0; f < NF; f++) begin : g_fld
      assign fld_eq[f] = (cur_time[f*FW +: FW] == alarm[f*FW +: FW]);
   end

   assign hit = upd && (&fld_eq);
endmodule

// File: rtl/dapc_regs.sv
module dapc_regs
   import dapc_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int WAKE_BASE   = 'h20,
   parameter int SHUT_BASE   = 'h80,
   parameter int STS_OFS     = 'h44,
   parameter int IEN_OFS     = 'h48,
   parameter int PCTL_OFS    = 'h98,
   parameter int PCTL_EN_BIT = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_we,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   input  logic                         busy,
   input  logic                         wake_hit,
   input  logic                         shut_hit,
   output logic [NUM_ALM-1:0][CAL_W-1:0] alm_vec,
   output logic                         ctl_en,
   output logic                         irq
);
   localparam int ALM_BASE [NUM_ALM] = '{WAKE_BASE, SHUT_BASE};
   localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(STS_OFS);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_OFS);
   localparam logic [ADDR_W-1:0] A_PCTL = ADDR_W'(PCTL_OFS);

   logic       sts_shut_q, sts_wake_q;
   logic [2:0] ien_q;     // {shut, wake, timer}
   logic       ctl_q;
   logic       clr_shut, clr_wake;
   logic       unused_wd;

   assign unused_wd = ^bus_wdata;

   // alarm field storage
   for (genvar a = 0; a < NUM_ALM; a++) begin : g_alm
      for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
         localparam logic [ADDR_W-1:0] FA = ADDR_W'(ALM_BASE[a] + 4*f);
         fld_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q <= '0;
            else if (bus_we && bus_addr == FA)   q <= bus_wdata[FLD_W-1:0];
         end
         assign alm_vec[a][f*FLD_W +: FLD_W] = q;
      end
   end

   assign clr_shut = bus_we && (bus_addr == A_STS) && bus_wdata[STS_SHUT_BIT];
   assign clr_wake = bus_we && (bus_addr == A_STS) && bus_wdata[STS_WAKE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_shut_q <= 1'b0;
         sts_wake_q <= 1'b0;
         ien_q      <= '0;
         ctl_q      <= 1'b0;
      end else begin
         sts_shut_q <= shut_hit || (sts_shut_q && !clr_shut);
         sts_wake_q <= wake_hit || (sts_wake_q && !clr_wake);
         if (bus_we && bus_addr == A_IEN)
            ien_q <= bus_wdata[IEN_SHUT_BIT:IEN_TMR_BIT];
         if (bus_we && bus_addr == A_PCTL)
            ctl_q <= bus_wdata[PCTL_EN_BIT];
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int a = 0; a < NUM_ALM; a++) begin
         for (int f = 0; f < NUM_FLD; f++) begin
            if (bus_addr == ADDR_W'(ALM_BASE[a] + 4*f))
               bus_rdata = DATA_W'(alm_vec[a][f*FLD_W +: FLD_W]);
         end
      end
      if (bus_addr == A_STS) begin
         bus_rdata[STS_SHUT_BIT] = sts_shut_q;
         bus_rdata[STS_WAKE_BIT] = sts_wake_q;
         bus_rdata[STS_BUSY_BIT] = busy;
      end
      if (bus_addr == A_IEN)
         bus_rdata[IEN_SHUT_BIT:IEN_TMR_BIT] = ien_q;
      if (bus_addr == A_PCTL)
         bus_rdata[PCTL_EN_BIT] = ctl_q;
   end

   assign ctl_en = ctl_q;
   assign irq    = (sts_shut_q && ien_q[2]) || (sts_wake_q && ien_q[1]);

   // R4
   shut_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_shut_q && !clr_shut) |=> sts_shut_q)
      else $error("shutdown flag lost without a clear");

   // R4
   wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wake_q && !clr_wake) |=> sts_wake_q)
      else $error("wake flag lost without a clear");
endmodule

// File: rtl/dapc_pwr.sv
module dapc_pwr
   import dapc_pkg::*;
#(
   parameter bit SHUT_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_en,
   input  logic shut_hit,
   input  logic wake_hit,
   output logic pwr_on
);
   pwr_st_e st_q, st_d;

   if (SHUT_WINS) begin : g_shut_first
      always_comb begin
         st_d = st_q;
         if (ctl_en && shut_hit)      st_d = PWR_OFF;
         else if (ctl_en && wake_hit) st_d = PWR_ON;
      end
   end else begin : g_wake_first
      always_comb begin
         st_d = st_q;
         if (ctl_en && wake_hit)      st_d = PWR_ON;
         else if (ctl_en && shut_hit) st_d = PWR_OFF;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PWR_ON;
      else        st_q <= st_d;
   end

   assign pwr_on = (st_q == PWR_ON);

   // R10
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |=> (pwr_on == $past(pwr_on)))
      else $error("pin moved while control disabled");

   // R8
   shut_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en && shut_hit && SHUT_WINS) |=> !pwr_on)
      else $error("shutdown match did not drop power");
endmodule

// File: rtl/dual_alarm_pwr_ctl.sv
module dual_alarm_pwr_ctl
   import dapc_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int WAKE_BASE   = 'h20,
   parameter int SHUT_BASE   = 'h80,
   parameter int STS_OFS     = 'h44,
   parameter int IEN_OFS     = 'h48,
   parameter int PCTL_OFS    = 'h98,
   parameter int PCTL_EN_BIT = 16,
   parameter bit SHUT_WINS   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CAL_W-1:0]  cur_time,
   input  logic              time_busy,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwr_en,
   output logic              irq
);
   localparam int SPAN = 4 * NUM_FLD;

   initial begin : prm_chk
      assert (PCTL_EN_BIT < DATA_W && DATA_W > STS_SHUT_BIT)
         else $error("data width too narrow for control bits");
      assert ((WAKE_BASE % 4) == 0 && (SHUT_BASE % 4) == 0)
         else $error("alarm bases must be word aligned");
      assert (WAKE_BASE + SPAN <= (1 << ADDR_W) && SHUT_BASE + SPAN <= (1 << ADDR_W))
         else $error("address width too small for alarm banks");
   end

   logic                          upd;
   logic [NUM_ALM-1:0]            hit;
   logic [NUM_ALM-1:0][CAL_W-1:0] alm_vec;
   logic                          ctl_en;

   dapc_tick #(.TIME_W(CAL_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .upd(upd)
   );

   for (genvar a = 0; a < NUM_ALM; a++) begin : g_cmp
      dapc_match #(.NF(NUM_FLD), .FW(FLD_W)) u_match (
         .cur_time(cur_time), .alarm(alm_vec[a]), .upd(upd), .hit(hit[a])
      );
   end

   dapc_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAKE_BASE(WAKE_BASE),
      .SHUT_BASE(SHUT_BASE), .STS_OFS(STS_OFS), .IEN_OFS(IEN_OFS),
      .PCTL_OFS(PCTL_OFS), .PCTL_EN_BIT(PCTL_EN_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(time_busy),
      .wake_hit(hit[ALM_WAKE]), .shut_hit(hit[ALM_SHUT]),
      .alm_vec(alm_vec), .ctl_en(ctl_en), .irq(irq)
   );

   dapc_pwr #(.SHUT_WINS(SHUT_WINS)) u_pwr (
      .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en),
      .shut_hit(hit[ALM_SHUT]), .wake_hit(hit[ALM_WAKE]), .pwr_on(pwr_en)
   );

   // R8
   wake_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en) |-> ($past(hit[ALM_WAKE]) && $past(ctl_en)))
      else $error("power restored without an enabled wake match");

   // R3
   no_hit_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(cur_time) |-> (hit == '0))
      else $error("alarm event without a time change");
endmodule

// File: tb/sim_dual_alarm_pwr_ctl.sv
module sim_dual_alarm_pwr_ctl;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 10;
   // {time, expected pwr_en, expected status[7:6]}
   localparam logic [50:0] VEC [NVEC] = '{
      {48'h250314100003, 1'b1, 2'b00},
      {48'h250314100004, 1'b1, 2'b00},
      {48'h250314100105, 1'b1, 2'b00},
      {48'h250314100005, 1'b0, 2'b10},
      {48'h250314100006, 1'b0, 2'b10},
      {48'h250314100009, 1'b1, 2'b11},
      {48'h250314100010, 1'b1, 2'b11},
      {48'h250314100005, 1'b0, 2'b11},
      {48'h250314110009, 1'b0, 2'b11},
      {48'h250314100009, 1'b1, 2'b11}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [47:0] cur_time = 48'h250314100000;
   logic        time_busy = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pwr_en, irq;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_alarm_pwr_ctl u0 (
      .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .time_busy(time_busy),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pwr_en(pwr_en), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
   endtask

   task automatic step(input logic [47:0] t);
      cur_time = t;
      @(negedge clk);
   endtask

   task automatic load_alarm(input logic [7:0] base, input logic [47:0] t);
      for (int f = 0; f < 6; f++) wr(base + 8'(4*f), {24'hABCDEF, t[f*8 +: 8]});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pwr_en", 32'(pwr_en), 32'd1);
      check("R1 irq", 32'(irq), 32'd0);
      rd(8'h44, 32'h0, "R1 status");
      rd(8'h48, 32'h0, "R1 ien");
      rd(8'h98, 32'h0, "R1 pctl");
      rd(8'h80, 32'h0, "R1 shut sec");
      rd(8'h20, 32'h0, "R1 wake sec");

      // setup
      load_alarm(8'h80, 48'h250314100005);
      load_alarm(8'h20, 48'h250314100009);
      rd(8'h94, 32'h25, "R2 shut year upper bits");
      rd(8'h88, 32'h10, "R2 shut hours");
      rd(8'h24, 32'h00, "R2 wake minutes");
      wr(8'h48, 32'h0000_0018);
      wr(8'h98, 32'h0001_0000);

      // table walk: R3 R8
      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][50:3]);
         check($sformatf("R8 table pwr step %0d", i), 32'(pwr_en), 32'(VEC[i][2]));
         rd(8'h44, {24'h0, VEC[i][1:0], 6'h0}, $sformatf("R3 table status step %0d", i));
         check($sformatf("R6 table irq step %0d", i), 32'(irq), 32'(|VEC[i][1:0]));
      end

      // R4 write-one-to-clear
      wr(8'h44, 32'h80);
      rd(8'h44, 32'h40, "R4 clear bit7 only");
      wr(8'h44, 32'h40);
      rd(8'h44, 32'h00, "R4 clear bit6");

      // R6 interrupt gating
      wr(8'h48, 32'h08);
      step(48'h250314100005);
      check("R8 shut drop", 32'(pwr_en), 32'd0);
      rd(8'h44, 32'h80, "R4 shut flag set");
      check("R6 irq masked", 32'(irq), 32'd0);
      wr(8'h48, 32'h10);
      check("R6 irq unmasked", 32'(irq), 32'd1);

      // R3 no repeat while time is held
      wr(8'h44, 32'h80);
      repeat (3) @(negedge clk);
      rd(8'h44, 32'h00, "R3 no repeat event");

      // R10 control disabled
      wr(8'h98, 32'h0);
      step(48'h250314100009);
      check("R10 pin held off", 32'(pwr_en), 32'd0);
      rd(8'h44, 32'h40, "R10 wake flag still set");
      step(48'h250314100005);
      check("R10 pin still off", 32'(pwr_en), 32'd0);
      wr(8'h98, 32'h0001_0000);
      step(48'h250314100009);
      check("R8 wake restores", 32'(pwr_en), 32'd1);

      // R9 simultaneous match
      wr(8'h20, 32'h05);
      step(48'h250314100006);
      check("R9 before match", 32'(pwr_en), 32'd1);
      step(48'h250314100005);
      check("R9 shutdown wins", 32'(pwr_en), 32'd0);
      rd(8'h44, 32'hC0, "R9 both flags");

      // R4 set wins over clear
      wr(8'h44, 32'hC0);
      rd(8'h44, 32'h00, "R4 cleared");
      step(48'h250314100007);
      cur_time = 48'h250314100005;
      bus_we = 1'b1; bus_addr = 8'h44; bus_wdata = 32'h80;
      @(negedge clk);
      bus_we = 1'b0;
      rd(8'h44, 32'hC0, "R4 set beats clear");

      // R4 busy mirror
      time_busy = 1'b1;
      rd(8'h44, 32'hC1, "R4 busy bit");
      time_busy = 1'b0;

      // R11 unmapped
      wr(8'h9C, 32'hFFFF_FFFF);
      wr(8'h38, 32'hFFFF_FFFF);
      rd(8'h9C, 32'h0, "R11 unmapped read");
      rd(8'h98, 32'h0001_0000, "R11 pctl untouched");
      rd(8'h34, 32'h25, "R11 wake year untouched");

      // R5 R7 full-word writes, R2 field width
      wr(8'h48, 32'hFFFF_FFFF);
      rd(8'h48, 32'h1C, "R5 ien full word");
      wr(8'h98, 32'hFFFF_FFFF);
      rd(8'h98, 32'h0001_0000, "R7 pctl single bit");
      wr(8'h80, 32'hFFFF_FF59);
      rd(8'h80, 32'h59, "R2 low byte stored");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule